// File: doc/BRIEF.md
# Same-Address Contention Arbiter for a Two-Port Memory

This block sits beside the storage array of a memory with two independent access ports, called left and right. Each cycle it looks at both ports' chip enables and addresses. When both ports are enabled on one address, it picks which access may go on. It then drives an active-low busy signal toward the other port. The memory uses that busy signal to block a write, and the requester can use it to stall until the conflict clears.

Arrival order is measured in clock cycles. For each port, the block remembers the cycle in which that port's enable/address pair last changed. On a match, the port whose pair settled earlier wins. When both settle in the same cycle, the left port wins. The decision depends only on enable and address. The read/write direction of each port has no effect on it.

Once made, a decision holds for as long as the match lasts. A combined contention flag is high whenever either busy is asserted, so it can serve as an interrupt that reports an illegal simultaneous access.

Top module: `dpa_contention_arb`

## Requirements
- R1: A busy output may be low only in the cycle after one in which both enables were high and the two addresses were equal. With differing addresses, or with either enable low, both busy outputs stay high.
- R2: On a match, the port whose enable/address pair changed more recently gets busy low. The port whose pair has been stable longer keeps busy high.
- R3: If both pairs change in the same cycle and match, the left port wins: `right_busy_n` goes low and `left_busy_n` stays high.
- R4: `left_busy_n` and `right_busy_n` are never low in the same cycle.
- R5: The direction inputs `left_we` and `right_we` have no effect on any output.
- R6: While a match continues with both pairs unchanged, the losing port stays fixed. Both busy outputs return high one cycle after the match ends, whether it ends through an address change or through either enable dropping.
- R7: `contention` is high exactly when either busy output is low.
- R8: All outputs are registered and change one clock after the inputs that cause them. While `rst_n` is low, both busy outputs are high and `contention` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| left_en | input | 1 | Left port chip enable, active high |
| left_addr | input | ADDR_W (11) | Left port address |
| left_we | input | 1 | Left port write direction (ignored by arbitration) |
| right_en | input | 1 | Right port chip enable, active high |
| right_addr | input | ADDR_W (11) | Right port address |
| right_we | input | 1 | Right port write direction (ignored by arbitration) |
| left_busy_n | output | 1 | Active-low busy toward the left port |
| right_busy_n | output | 1 | Active-low busy toward the right port |
| contention | output | 1 | High while either busy is asserted |

## Verification
Every result of this block is due exactly one clock after the inputs that cause it. The bench applies new inputs on the falling edge. A behavioural model, built on per-port arrival stamps, updates on the rising edge. The three outputs are then compared with that model on the following falling edge, in every cycle. The directed phases cover left-first, right-first and same-cycle arrivals, direction toggling during a held match, and release through an address change or through an enable drop. A random phase on a two-address space then mixes all of these cases.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    VERDICT_NONE        = 2'd0,
    VERDICT_LEFT_LOSES  = 2'd1,
    VERDICT_RIGHT_LOSES = 2'd2
  } verdict_e;
endpackage

// File: rtl/dpa_arrival.sv
// Flags the cycle in which a port's enable/address pair differs from the
// pair seen on the previous clock (its arrival).
module dpa_arrival #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              changed
);
  logic              prev_en;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_en   <= 1'b0;
      prev_addr <= '0;
    end else begin
      prev_en   <= en;
      prev_addr <= addr;
    end
  end

  assign changed = (en != prev_en) || (addr != prev_addr);
endmodule

// File: rtl/dpa_match.sv
module dpa_match #(
  parameter int ADDR_W = 11
) (
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              hit
);
  assign hit = l_en && r_en && (l_addr == r_addr);
endmodule

// File: rtl/dpa_decide.sv
module dpa_decide
  import dpa_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hit,
  input  logic     l_chg,
  input  logic     r_chg,
  output verdict_e verdict
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      verdict <= VERDICT_NONE;
    else if (!hit)
      verdict <= VERDICT_NONE;
    else if (l_chg || r_chg)
      verdict <= (l_chg && !r_chg) ? VERDICT_LEFT_LOSES : VERDICT_RIGHT_LOSES;
  end

  // R3: same-cycle arrival on a match is won by the left port
  p_tie_left_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && l_chg && r_chg) |=> (verdict == VERDICT_RIGHT_LOSES));

  // R6: a settled match keeps its verdict
  p_verdict_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !l_chg && !r_chg) |=> $stable(verdict));
endmodule

// File: rtl/dpa_contention_arb.sv
module dpa_contention_arb
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              left_en,
  input  logic [ADDR_W-1:0] left_addr,
  input  logic              left_we,
  input  logic              right_en,
  input  logic [ADDR_W-1:0] right_addr,
  input  logic              right_we,
  output logic              left_busy_n,
  output logic              right_busy_n,
  output logic              contention
);
  localparam int NPORT = 2;

  logic              en_v   [NPORT];
  logic [ADDR_W-1:0] addr_v [NPORT];
  logic              chg_v  [NPORT];
  logic              hit;
  verdict_e          verdict;

  assign en_v[0]   = left_en;
  assign addr_v[0] = left_addr;
  assign en_v[1]   = right_en;
  assign addr_v[1] = right_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpa_arrival #(.ADDR_W(ADDR_W)) u_arrival (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en_v[p]),
      .addr   (addr_v[p]),
      .changed(chg_v[p])
    );
  end

  dpa_match #(.ADDR_W(ADDR_W)) u_match (
    .l_en  (left_en),
    .l_addr(left_addr),
    .r_en  (right_en),
    .r_addr(right_addr),
    .hit   (hit)
  );

  dpa_decide u_decide (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit),
    .l_chg  (chg_v[0]),
    .r_chg  (chg_v[1]),
    .verdict(verdict)
  );

  assign left_busy_n  = (verdict != VERDICT_LEFT_LOSES);
  assign right_busy_n = (verdict != VERDICT_RIGHT_LOSES);
  assign contention   = (verdict != VERDICT_NONE);

  // R1: busy low only after a cycle with both enabled on equal addresses
  p_busy_needs_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!left_busy_n || !right_busy_n) |->
      $past(left_en && right_en && (left_addr == right_addr)));

  // R4: never both busy
  p_busy_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!left_busy_n && !right_busy_n));

  // R6: release one cycle after the match ends
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(left_en && right_en && (left_addr == right_addr)) |=>
      (left_busy_n && right_busy_n));

  // R5: toggling direction during a steady match leaves busy unchanged
  p_dir_blind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (contention && left_en && right_en && (left_addr == right_addr) &&
     $stable(left_addr) && $stable(right_addr) &&
     $stable(left_en) && $stable(right_en) &&
     ($changed(left_we) || $changed(right_we)))
      |=> ($stable(left_busy_n) && $stable(right_busy_n)));

  // R7: the flag follows a busy indication, so it too needs a prior match
  p_flag_needs_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    contention |-> $past(hit));
endmodule

// File: tb/dpa_contention_arb_tb.sv
module dpa_contention_arb_tb;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          left_en = 1'b0, right_en = 1'b0;
  logic [AW-1:0] left_addr = '0, right_addr = '0;
  logic          left_we = 1'b0, right_we = 1'b0;
  logic          left_busy_n, right_busy_n, contention;

  always #10 clk = ~clk;

  dpa_contention_arb #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .left_en(left_en), .left_addr(left_addr), .left_we(left_we),
    .right_en(right_en), .right_addr(right_addr), .right_we(right_we),
    .left_busy_n(left_busy_n), .right_busy_n(right_busy_n),
    .contention(contention)
  );

  int    checks = 0;
  int    fails  = 0;
  string tag    = "R8";
  bit    done   = 1'b0;

  // Reference model: arrival stamps per port
  int            cyc = 0;
  logic          pl_en = 1'b0, pr_en = 1'b0;
  logic [AW-1:0] pl_a = '0, pr_a = '0;
  int            sl = 0, sr = 0;
  logic          exp_l = 1'b1, exp_r = 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      pl_en = 1'b0; pr_en = 1'b0; pl_a = '0; pr_a = '0;
      sl = 0; sr = 0; exp_l = 1'b1; exp_r = 1'b1;
    end else begin
      cyc++;
      if (left_en != pl_en || left_addr != pl_a) sl = cyc;
      if (right_en != pr_en || right_addr != pr_a) sr = cyc;
      pl_en = left_en; pl_a = left_addr; pr_en = right_en; pr_a = right_addr;
      if (!(left_en && right_en && left_addr == right_addr)) begin
        exp_l = 1'b1; exp_r = 1'b1;
      end else if (sl > sr) begin
        exp_l = 1'b0; exp_r = 1'b1;
      end else begin
        exp_l = 1'b1; exp_r = 1'b0;
      end
    end
  end

  task automatic compare();
    logic exp_c;
    exp_c = !exp_l || !exp_r;
    checks++;
    if ({left_busy_n, right_busy_n, contention} !== {exp_l, exp_r, exp_c}) begin
      fails++;
      $display("FAIL %s: busy_l/busy_r/contention = %b%b%b expected %b%b%b",
               tag, left_busy_n, right_busy_n, contention, exp_l, exp_r, exp_c);
    end
    checks++;
    if (!left_busy_n && !right_busy_n) begin
      fails++;
      $display("FAIL R4: busy_l/busy_r = %b%b expected not both 0",
               left_busy_n, right_busy_n);
    end
  endtask

  // called at a falling edge: drive, let one rising edge pass, check
  task automatic step(input logic le, input logic [AW-1:0] la, input logic lw,
                      input logic re, input logic [AW-1:0] ra, input logic rw);
    left_en = le; left_addr = la; left_we = lw;
    right_en = re; right_addr = ra; right_we = rw;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    tag = "R8";
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare();                                   // R8 reset state
    rst_n = 1'b1;
    tag = "R1";                                  // different addresses
    step(1, 11'h010, 0, 1, 11'h011, 0);
    step(1, 11'h010, 1, 1, 11'h011, 1);
    step(1, 11'h7FF, 0, 0, 11'h7FF, 0);          // R1 right disabled
    step(0, 11'h7FF, 0, 1, 11'h7FF, 0);          // R1 left disabled
    step(0, 11'h000, 0, 0, 11'h000, 0);
    tag = "R2";                                  // left first, right arrives
    step(1, 11'h123, 0, 0, 11'h000, 0);
    step(1, 11'h123, 0, 1, 11'h123, 1);
    step(1, 11'h123, 0, 1, 11'h123, 1);
    tag = "R5";                                  // direction toggles held
    step(1, 11'h123, 1, 1, 11'h123, 0);
    step(1, 11'h123, 0, 1, 11'h123, 1);
    tag = "R6";                                  // release via addr change
    step(1, 11'h124, 0, 1, 11'h123, 0);
    step(1, 11'h124, 0, 1, 11'h123, 0);
    tag = "R2";                                  // right first, left arrives
    step(1, 11'h123, 1, 1, 11'h123, 0);
    step(1, 11'h123, 1, 1, 11'h123, 0);
    tag = "R6";                                  // release via enable drop
    step(1, 11'h123, 1, 0, 11'h123, 0);
    step(0, 11'h000, 0, 0, 11'h000, 0);
    tag = "R3";                                  // same-cycle arrival
    step(1, 11'h055, 0, 1, 11'h055, 1);
    step(1, 11'h055, 1, 1, 11'h055, 0);
    tag = "R3";                                  // both move to new equal addr
    step(1, 11'h056, 0, 1, 11'h056, 0);
    tag = "R7";
    step(1, 11'h056, 0, 0, 11'h056, 0);
    tag = "R2";                                  // random mix on two addresses
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 4) != 0, 11'h200 + 11'($urandom % 2), 1'($urandom),
           ($urandom % 4) != 0, 11'h200 + 11'($urandom % 2), 1'($urandom));
    end
    tag = "R8";                                  // reset mid-contention
    step(1, 11'h300, 0, 1, 11'h300, 0);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule